// File: doc/BRIEF.md
# Accumulator and Extend-Bit Arithmetic Unit

This unit holds a processor's working accumulator and its one-bit extend (carry) flip-flop, and changes them when the control sequencer asks. The sequencer drives a vector of one-hot strobes, one bit per operation. In the clock edge where a strobe is high, the unit applies that operation to the accumulator, the extend bit, and the operand presented by the data register. The operations are: load, add with carry out, bitwise AND, clear and complement of the accumulator, clear and complement of the extend bit, increment, and rotates in both directions through the extend bit.

The rotates treat the extend bit and the accumulator as one ring of DATA_W+1 bits. Four combinational flags (accumulator zero, negative, positive, and extend zero) feed the sequencer's skip decisions without an added cycle. Instruction decoding, memory access and sequencing are done outside this block. The strobes and the operand are plain control and data pins with no handshake, because the unit accepts one operation on every clock.

Top module: `acc_ext_alu`

## Requirements
- R1: While `rst_n` is low, and after it rises, `acc` is 0 and `ext` is 0.
- R2: In a clock with no strobe bit set, `acc` and `ext` keep their values.
- R3: When more than one strobe bit is set, only the operation with the lowest bit index is carried out in that clock.
- R4: Strobe bit 0 (load) sets `acc` to `operand` and leaves `ext` unchanged.
- R5: Strobe bit 1 (add) sets the (DATA_W+1)-bit value {`ext`,`acc`} to `acc` + `operand`, so `ext` receives the carry out.
- R6: Strobe bit 2 (and) sets `acc` to `acc` & `operand` and leaves `ext` unchanged.
- R7: Strobe bit 3 clears `acc` and strobe bit 4 inverts every bit of `acc`. Neither changes `ext`.
- R8: Strobe bit 5 clears `ext` and strobe bit 6 inverts `ext`. Neither changes `acc`.
- R9: Strobe bit 7 (rotate right) sets `acc` to {`ext`, `acc`[DATA_W-1:1]} and `ext` to the old `acc`[0].
- R10: Strobe bit 8 (rotate left) sets `acc` to {`acc`[DATA_W-2:0], `ext`} and `ext` to the old `acc`[DATA_W-1].
- R11: Strobe bit 9 (increment) adds one to `acc` modulo 2^DATA_W and leaves `ext` unchanged.
- R12: `acc_zero` is high when `acc` is 0. `acc_neg` is high when the top bit of `acc` is 1. `acc_pos` is high when `acc` is nonzero and its top bit is 0. `ext_zero` is high when `ext` is 0. All four follow the registers with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 10 | Operation strobes; bit index selects the operation, lowest set bit wins |
| operand | input | DATA_W | Operand from the data register |
| acc | output | DATA_W | Accumulator |
| ext | output | 1 | Extend (carry) bit |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_neg | output | 1 | Accumulator top bit set |
| acc_pos | output | 1 | Accumulator nonzero with top bit clear |
| ext_zero | output | 1 | Extend bit is zero |

## Verification
The per-operation properties fire only when the strobe vector equals exactly one bit. They assume that `strobe` and `operand` carry known values at every rising edge after reset. The bench changes these inputs only on falling edges and clears the strobe between operations, so each sampled edge sees one settled value. Clocks with several strobe bits set are used only in the priority sweep. There the single-bit properties stay inactive, and the bench's own model checks that the lowest set bit wins.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  // Strobe bit positions; lower index has priority.
  localparam int unsigned IX_LOAD    = 0;
  localparam int unsigned IX_ADD     = 1;
  localparam int unsigned IX_AND     = 2;
  localparam int unsigned IX_CLR_ACC = 3;
  localparam int unsigned IX_CPL_ACC = 4;
  localparam int unsigned IX_CLR_EXT = 5;
  localparam int unsigned IX_CPL_EXT = 6;
  localparam int unsigned IX_ROT_R   = 7;
  localparam int unsigned IX_ROT_L   = 8;
  localparam int unsigned IX_INC     = 9;

  localparam int unsigned N_STRB = 10;
  localparam int unsigned SEL_W  = $clog2(N_STRB + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_LOAD    = SEL_W'(IX_LOAD),
    SEL_ADD     = SEL_W'(IX_ADD),
    SEL_AND     = SEL_W'(IX_AND),
    SEL_CLR_ACC = SEL_W'(IX_CLR_ACC),
    SEL_CPL_ACC = SEL_W'(IX_CPL_ACC),
    SEL_CLR_EXT = SEL_W'(IX_CLR_EXT),
    SEL_CPL_EXT = SEL_W'(IX_CPL_EXT),
    SEL_ROT_R   = SEL_W'(IX_ROT_R),
    SEL_ROT_L   = SEL_W'(IX_ROT_L),
    SEL_INC     = SEL_W'(IX_INC),
    SEL_NONE    = SEL_W'(N_STRB)
  } alu_sel_e;

endpackage

// File: rtl/acc_alu_pick.sv
module acc_alu_pick
  import acc_alu_pkg::*;
#(
  parameter int unsigned N = N_STRB
) (
  input  logic [N-1:0] strb,
  output logic [N-1:0] grant,
  output alu_sel_e     sel
);

  // Running OR of all lower strobe bits.
  logic [N:0] below;

  assign below[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_arb
    assign grant[g]   = strb[g] & ~below[g];
    assign below[g+1] = below[g] | strb[g];
  end

  always_comb begin
    sel = SEL_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant[i]) begin
        sel = alu_sel_e'(SEL_W'(i));
      end
    end
  end

endmodule

// File: rtl/acc_alu_calc.sv
module acc_alu_calc
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_sel_e     sel,
  input  logic [W-1:0] acc_q,
  input  logic         ext_q,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] acc_d,
  output logic         ext_d
);

  localparam int unsigned SW = W + 1;

  logic [SW-1:0] add_sum;
  logic [W-1:0]  inc_val;
  logic [SW-1:0] ring_r;
  logic [SW-1:0] ring_l;

  assign add_sum = {1'b0, acc_q} + {1'b0, opnd};
  assign inc_val = acc_q + W'(1);

  // Ring of W+1 bits, extend bit on top.
  assign ring_r = {acc_q[0], ext_q, acc_q[W-1:1]};
  assign ring_l = {acc_q[W-1], acc_q[W-2:0], ext_q};

  always_comb begin
    acc_d = acc_q;
    ext_d = ext_q;
    unique case (sel)
      SEL_LOAD:    acc_d = opnd;
      SEL_ADD:     {ext_d, acc_d} = add_sum;
      SEL_AND:     acc_d = acc_q & opnd;
      SEL_CLR_ACC: acc_d = '0;
      SEL_CPL_ACC: acc_d = ~acc_q;
      SEL_CLR_EXT: ext_d = 1'b0;
      SEL_CPL_EXT: ext_d = ~ext_q;
      SEL_ROT_R:   {ext_d, acc_d} = ring_r;
      SEL_ROT_L:   {ext_d, acc_d} = ring_l;
      SEL_INC:     acc_d = inc_val;
      SEL_NONE:    ;
      default:     ;
    endcase
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] acc_q,
  input  logic         ext_q,
  output logic         f_zero,
  output logic         f_neg,
  output logic         f_pos,
  output logic         f_ezero
);

  logic any_set;

  assign any_set = |acc_q;
  assign f_zero  = ~any_set;
  assign f_neg   = acc_q[W-1];
  assign f_pos   = any_set & ~acc_q[W-1];
  assign f_ezero = ~ext_q;

endmodule

// File: rtl/acc_ext_alu.sv
module acc_ext_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_STRB-1:0] strobe,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic              ext,
  output logic              acc_zero,
  output logic              acc_neg,
  output logic              acc_pos,
  output logic              ext_zero
);

  logic [N_STRB-1:0] grant;
  alu_sel_e          sel;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              ext_q, ext_d;

  acc_alu_pick #(.N(N_STRB)) u_pick (
    .strb  (strobe),
    .grant (grant),
    .sel   (sel)
  );

  acc_alu_calc #(.W(DATA_W)) u_calc (
    .sel   (sel),
    .acc_q (acc_q),
    .ext_q (ext_q),
    .opnd  (operand),
    .acc_d (acc_d),
    .ext_d (ext_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (|grant) begin
      acc_q <= acc_d;
      ext_q <= ext_d;
    end
  end

  acc_alu_flags #(.W(DATA_W)) u_flags (
    .acc_q   (acc_q),
    .ext_q   (ext_q),
    .f_zero  (acc_zero),
    .f_neg   (acc_neg),
    .f_pos   (acc_pos),
    .f_ezero (ext_zero)
  );

  assign acc = acc_q;
  assign ext = ext_q;

endmodule

// File: rtl/acc_ext_alu_chk.sv
module acc_ext_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_STRB-1:0] strobe,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] acc,
  input logic              ext,
  input logic              acc_zero,
  input logic              acc_neg,
  input logic              acc_pos,
  input logic              ext_zero
);

  localparam logic [N_STRB-1:0] ONE = N_STRB'(1);

  always_comb begin
    if (rst_n) begin
      AST_SIGN_CLASS: assert ($onehot({acc_zero, acc_neg, acc_pos})); // R12
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == '0 |=> $stable(acc) && $stable(ext)); // R2

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (ONE << IX_LOAD) |=> acc == $past(operand) && $stable(ext)); // R4

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (ONE << IX_ADD) |=>
      {ext, acc} == ({1'b0, $past(acc)} + {1'b0, $past(operand)})); // R5

  AST_EXT_OPS_KEEP_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe == (ONE << IX_CLR_EXT)) || (strobe == (ONE << IX_CPL_EXT)) |=>
      $stable(acc)); // R8

  AST_CLR_EXT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (ONE << IX_CLR_EXT) |=> !ext); // R8

  AST_ROT_R_RING: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (ONE << IX_ROT_R) |=>
      ext == $past(acc[0]) && acc[DATA_W-1] == $past(ext)); // R9

  AST_ROT_L_RING: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (ONE << IX_ROT_L) |=>
      ext == $past(acc[DATA_W-1]) && acc[0] == $past(ext)); // R10

  AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (ONE << IX_INC) |=>
      acc == DATA_W'($past(acc) + DATA_W'(1)) && $stable(ext)); // R11

  AST_PRIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[IX_LOAD] |=> acc == $past(operand)); // R3

endmodule

bind acc_ext_alu acc_ext_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_acc_ext_alu.sv
`timescale 1ns/1ps
module test_acc_ext_alu;
  import acc_alu_pkg::*;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_STRB-1:0] strobe = '0;
  logic [W-1:0]      operand = '0;
  logic [W-1:0]      acc;
  logic              ext, acc_zero, acc_neg, acc_pos, ext_zero;

  int vecs = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  acc_ext_alu #(.DATA_W(W)) i_acc_ext_alu (
    .clk, .rst_n, .strobe, .operand, .acc, .ext,
    .acc_zero, .acc_neg, .acc_pos, .ext_zero
  );

  function automatic string tag_of(int k);
    case (k)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3, 4: return "R7";
      5, 6: return "R8";
      7: return "R9";
      8: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Arithmetic model of one operation.
  task automatic model(input int k, input int a, input int e, input int b,
                       output int na, output int ne);
    na = a; ne = e;
    case (k)
      0: na = b;
      1: begin na = (a + b) % M; ne = (a + b) / M; end
      2: na = a & b;
      3: na = 0;
      4: na = M - 1 - a;
      5: ne = 0;
      6: ne = 1 - e;
      7: begin na = e * (M / 2) + a / 2; ne = a % 2; end
      8: begin na = (a * 2) % M + e; ne = a / (M / 2); end
      default: na = (a + 1) % M;
    endcase
  endtask

  task automatic check(input string tag, input int xa, input int xe);
    int fz, fn, fp, fe;
    fz = (xa == 0); fn = (xa >= M / 2); fp = (xa != 0 && xa < M / 2); fe = (xe == 0);
    vecs++;
    if (int'(acc) != xa || int'(ext) != xe || int'(acc_zero) != fz ||
        int'(acc_neg) != fn || int'(acc_pos) != fp || int'(ext_zero) != fe) begin
      bad++;
      $display("FAIL %s/R12: acc=%0d ext=%0d z/n/p/ez=%0d%0d%0d%0d expected acc=%0d ext=%0d z/n/p/ez=%0d%0d%0d%0d",
               tag, acc, ext, acc_zero, acc_neg, acc_pos, ext_zero, xa, xe, fz, fn, fp, fe);
    end
  endtask

  task automatic apply(input logic [N_STRB-1:0] s, input int d);
    strobe = s; operand = W'(d);
    @(negedge clk);
    strobe = '0;
  endtask

  task automatic preset(input int a, input int e);
    apply(N_STRB'(1) << IX_LOAD, a);
    apply(N_STRB'(1) << IX_CLR_EXT, 0);
    if (e != 0) apply(N_STRB'(1) << IX_CPL_EXT, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(1_000_000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    int na, ne;
    repeat (3) @(negedge clk);
    check("R1", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, 0);

    // Exhaustive single-strobe sweep.
    for (int k = 0; k < N_STRB; k++)
      for (int a = 0; a < M; a++)
        for (int e = 0; e < 2; e++)
          for (int b = 0; b < M; b++) begin
            preset(a, e);
            apply(N_STRB'(1) << k, b);
            model(k, a, e, b, na, ne);
            check(tag_of(k), na, ne);
            if (b == 0) begin
              // R2: idle clock with a live operand
              apply('0, M - 1);
              check("R2", na, ne);
            end
          end

    // R3: every pair of strobes, lowest index must win.
    for (int i = 0; i < N_STRB; i++)
      for (int j = i + 1; j < N_STRB; j++) begin
        preset(5 % M, 1);
        apply((N_STRB'(1) << i) | (N_STRB'(1) << j), 9 % M);
        model(i, 5 % M, 1, 9 % M, na, ne);
        check("R3", na, ne);
      end

    // R3: all strobes set at once
    preset(6, 0);
    apply('1, 3);
    check("R3", 3, 0);

    // R1: asynchronous reset mid-run
    preset(M - 1, 1);
    #1 rst_n = 1'b0;
    #1 check("R1", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, 0);

    finish_run();
  end

endmodule